// File: doc/BRIEF.md
# Main Power Domain Sequencer

This block runs on the always-on clock and orders the control lines that take the main core supply down and bring it back up. A sleep request starts the descent: an early isolation warning goes up first, the full isolation enable follows a set number of cycles later, the block then waits until flash reports that it is ready for power loss, and only then drives the active-low power control to zero. The reset to the switched logic is held asserted while power is off.

A wake request starts the climb back. A wake that arrives while the descent is still under way is latched and acted on once the power-off state is reached. On the way up the block turns the supply back on and waits for the power-good status. It then releases reset to the switched logic, keeps isolation up for a hold period, drops isolation, and drops the early warning a set number of cycles after that. A timeout counter raises a sticky error flag if power-good does not reach its expected level in time after either supply transition.

The block carries no data stream. All pins are plain level controls and status, so it has no valid/ready handshake and no back-pressure.

Top module: `main_pwr_seq`

## Requirements
- R1: After reset the outputs are: early_iso_o=0, iso_o=0, pwr_on_o=1, main_rst_no=1, state_o=0, timeout_err_o=0.
- R2: iso_o rises exactly ISO_LEAD_CYC cycles after early_iso_o rises. The lead is at least one cycle, and iso_o is never high while early_iso_o is low.
- R3: pwr_on_o falls only in the cycle after flash_ready_i has been sampled high while the sequencer is waiting for flash. It stays 1 for as long as flash_ready_i is low.
- R4: pwr_on_o=0 only while both iso_o and early_iso_o are 1.
- R5: A wake_req_i pulse given at any point after the sleep request is latched. pwr_on_o returns to 1 only after such a wake, and the sequence then returns to state_o=0.
- R6: main_rst_no is 0 while power is off or not yet good. It rises only after pwr_good_i has been sampled high. iso_o falls exactly RST_HOLD_CYC cycles after main_rst_no rises.
- R7: early_iso_o falls exactly ISO_LAG_CYC cycles after iso_o falls.
- R8: timeout_err_o rises exactly PWR_TIMEOUT_CYC cycles after a pwr_on_o edge if pwr_good_i has not yet followed that edge. The flag is sticky and is cleared when the next sleep request is accepted.
- R9: sleep_req_i is ignored outside state_o=0, and wake_req_i is ignored in state_o=0. Neither starts a new sequence.
- R10: state_o encodes 0 active, 1 early-isolation, 2 isolation, 3 flash wait, 4 power off, 5 power-on wait, 6 reset release, 7 isolation release, 8 early-isolation release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Request to remove main power |
| wake_req_i | input | 1 | Request to restore main power |
| pwr_good_i | input | 1 | Main supply is present |
| flash_ready_i | input | 1 | Flash is prepared for power loss |
| early_iso_o | output | 1 | Early isolation warning |
| iso_o | output | 1 | Isolation enable |
| pwr_on_o | output | 1 | Power control, 0 = main power off |
| main_rst_no | output | 1 | Active-low reset to the switched logic |
| state_o | output | 4 | Sequencer state (R10 encoding) |
| timeout_err_o | output | 1 | Sticky power-good timeout flag |

## Verification
The timeout paths are the hardest cases to reach from the ports, because they need power-good to stay where it is after a supply transition. A normal run never produces that. The bench models the supply switch as power-good following the power control after a random delay, and it can freeze that model. Directed runs freeze power-good high across a power-off and low across a power-on, so the error arrives at a known cycle. Random runs also place the wake pulse anywhere from the early-warning phase to deep sleep, which exercises the latched-wake path.

// File: rtl/main_pwr_seq_pkg.sv
package main_pwr_seq_pkg;

  typedef enum logic [3:0] {
    PS_ACTIVE            = 4'd0,
    PS_EARLY_ISO         = 4'd1,
    PS_ISO               = 4'd2,
    PS_FLASH_PREP        = 4'd3,
    PS_POWER_OFF         = 4'd4,
    PS_POWER_ON_WAIT     = 4'd5,
    PS_RESET_RELEASE     = 4'd6,
    PS_ISO_RELEASE       = 4'd7,
    PS_EARLY_ISO_RELEASE = 4'd8
  } pwr_state_e;

  typedef struct packed {
    logic early_iso;
    logic iso;
    logic pwr_on;
    logic rst_n;
  } pwr_ctl_t;

endpackage

// File: rtl/main_pwr_seq_timer.sv
module main_pwr_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  // Counts down to zero and stays there until the next load.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/main_pwr_seq_fsm.sv
module main_pwr_seq_fsm
  import main_pwr_seq_pkg::*;
#(
  parameter int LEAD = 1,
  parameter int LAG  = 1,
  parameter int HOLD = 1,
  parameter int TOUT = 40,
  parameter int W    = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_req_i,
  input  logic         wake_req_i,
  input  logic         pwr_good_i,
  input  logic         flash_ready_i,
  input  logic         tmr_done_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output pwr_state_e   state_o,
  output logic         err_o
);

  pwr_state_e state_q, state_d;
  logic       wake_pend_q;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACTIVE:            if (sleep_req_i)   state_d = PS_EARLY_ISO;
      PS_EARLY_ISO:         if (tmr_done_i)    state_d = PS_ISO;
      PS_ISO:                                  state_d = PS_FLASH_PREP;
      PS_FLASH_PREP:        if (flash_ready_i) state_d = PS_POWER_OFF;
      PS_POWER_OFF:         if (wake_pend_q)   state_d = PS_POWER_ON_WAIT;
      PS_POWER_ON_WAIT:     if (pwr_good_i)    state_d = PS_RESET_RELEASE;
      PS_RESET_RELEASE:     if (tmr_done_i)    state_d = PS_ISO_RELEASE;
      PS_ISO_RELEASE:       if (tmr_done_i)    state_d = PS_EARLY_ISO_RELEASE;
      PS_EARLY_ISO_RELEASE:                    state_d = PS_ACTIVE;
      default:                                 state_d = PS_ACTIVE;
    endcase
  end

  // The timer restarts on every state change. The window it loads
  // depends on the state being entered.
  always_comb begin
    tmr_load_o = (state_d != state_q);
    unique case (state_d)
      PS_EARLY_ISO:                       tmr_val_o = W'(LEAD - 1);
      PS_POWER_OFF, PS_POWER_ON_WAIT:     tmr_val_o = W'(TOUT - 1);
      PS_RESET_RELEASE:                   tmr_val_o = W'(HOLD - 1);
      PS_ISO_RELEASE:                     tmr_val_o = W'(LAG - 1);
      default:                            tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_ACTIVE;
      wake_pend_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_ACTIVE || (state_q == PS_POWER_OFF && wake_pend_q))
        wake_pend_q <= 1'b0;
      else if (wake_req_i)
        wake_pend_q <= 1'b1;
      if (state_q == PS_ACTIVE && sleep_req_i)
        err_q <= 1'b0;
      else if (tmr_done_i &&
               ((state_q == PS_POWER_OFF && pwr_good_i) ||
                (state_q == PS_POWER_ON_WAIT && !pwr_good_i)))
        err_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

endmodule

// File: rtl/main_pwr_seq_decode.sv
module main_pwr_seq_decode
  import main_pwr_seq_pkg::*;
(
  input  pwr_state_e state_i,
  output pwr_ctl_t   ctl_o
);

  always_comb begin
    unique case (state_i)
      PS_ACTIVE, PS_EARLY_ISO_RELEASE: ctl_o = '{early_iso: 1'b0, iso: 1'b0, pwr_on: 1'b1, rst_n: 1'b1};
      PS_EARLY_ISO, PS_ISO_RELEASE:    ctl_o = '{early_iso: 1'b1, iso: 1'b0, pwr_on: 1'b1, rst_n: 1'b1};
      PS_ISO, PS_FLASH_PREP,
      PS_RESET_RELEASE:                ctl_o = '{early_iso: 1'b1, iso: 1'b1, pwr_on: 1'b1, rst_n: 1'b1};
      PS_POWER_OFF:                    ctl_o = '{early_iso: 1'b1, iso: 1'b1, pwr_on: 1'b0, rst_n: 1'b0};
      PS_POWER_ON_WAIT:                ctl_o = '{early_iso: 1'b1, iso: 1'b1, pwr_on: 1'b1, rst_n: 1'b0};
      default:                         ctl_o = '{early_iso: 1'b0, iso: 1'b0, pwr_on: 1'b1, rst_n: 1'b1};
    endcase
  end

endmodule

// File: rtl/main_pwr_seq.sv
module main_pwr_seq
  import main_pwr_seq_pkg::*;
#(
  parameter int ISO_LEAD_CYC    = 1,
  parameter int ISO_LAG_CYC     = 1,
  parameter int RST_HOLD_CYC    = 2,
  parameter int PWR_TIMEOUT_CYC = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       pwr_good_i,
  input  logic       flash_ready_i,
  output logic       early_iso_o,
  output logic       iso_o,
  output logic       pwr_on_o,
  output logic       main_rst_no,
  output logic [3:0] state_o,
  output logic       timeout_err_o
);

  localparam int LEAD  = (ISO_LEAD_CYC    < 1) ? 1 : ISO_LEAD_CYC;
  localparam int LAG   = (ISO_LAG_CYC     < 1) ? 1 : ISO_LAG_CYC;
  localparam int HOLD  = (RST_HOLD_CYC    < 1) ? 1 : RST_HOLD_CYC;
  localparam int TOUT  = (PWR_TIMEOUT_CYC < 1) ? 1 : PWR_TIMEOUT_CYC;
  localparam int MAX_A = (LEAD > LAG) ? LEAD : LAG;
  localparam int MAX_B = (HOLD > TOUT) ? HOLD : TOUT;
  localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAXV + 1);

  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  pwr_state_e    state;
  pwr_ctl_t      ctl;

  main_pwr_seq_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  main_pwr_seq_fsm #(
    .LEAD (LEAD), .LAG (LAG), .HOLD (HOLD), .TOUT (TOUT), .W (TW)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .wake_req_i    (wake_req_i),
    .pwr_good_i    (pwr_good_i),
    .flash_ready_i (flash_ready_i),
    .tmr_done_i    (tmr_done),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .state_o       (state),
    .err_o         (timeout_err_o)
  );

  main_pwr_seq_decode u_dec (
    .state_i (state),
    .ctl_o   (ctl)
  );

  assign early_iso_o = ctl.early_iso;
  assign iso_o       = ctl.iso;
  assign pwr_on_o    = ctl.pwr_on;
  assign main_rst_no = ctl.rst_n;
  assign state_o     = state;

endmodule

// File: rtl/main_pwr_seq_chk.sv
module main_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       flash_ready_i,
  input logic       early_iso_o,
  input logic       iso_o,
  input logic       pwr_on_o,
  input logic       main_rst_no,
  input logic [3:0] state_o
);

  AST_ISO_INSIDE_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_o |-> early_iso_o); // R2
  AST_ISO_RISE_AFTER_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> $past(early_iso_o)); // R2
  AST_PWR_CUT_NEEDS_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_on_o) |-> $past(flash_ready_i)); // R3
  AST_PWR_OFF_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_o |-> (iso_o && early_iso_o)); // R4
  AST_RST_AFTER_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_rst_no) |-> $past(pwr_good_i)); // R6
  AST_ISO_DROP_OUT_OF_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_o) |-> main_rst_no); // R6
  AST_EARLY_DROP_AFTER_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(early_iso_o) |-> $past(!iso_o)); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 4'd8); // R10

endmodule

bind main_pwr_seq main_pwr_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_good_i    (pwr_good_i),
  .flash_ready_i (flash_ready_i),
  .early_iso_o   (early_iso_o),
  .iso_o         (iso_o),
  .pwr_on_o      (pwr_on_o),
  .main_rst_no   (main_rst_no),
  .state_o       (state_o)
);

// File: tb/main_pwr_seq_tb.sv
module main_pwr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 3;
  localparam int LAG  = 2;
  localparam int HOLD = 2;
  localparam int TO   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0, wake = 1'b0, pg = 1'b1, flash = 1'b0;
  logic early, iso, pwr_on, mrst_n, err;
  logic [3:0] state;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit wake_given = 1'b0;
  bit pg_stuck = 1'b0;
  int pg_delay = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  main_pwr_seq #(
    .ISO_LEAD_CYC (LEAD), .ISO_LAG_CYC (LAG),
    .RST_HOLD_CYC (HOLD), .PWR_TIMEOUT_CYC (TO)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .sleep_req_i (sleep), .wake_req_i (wake),
    .pwr_good_i (pg), .flash_ready_i (flash), .early_iso_o (early), .iso_o (iso),
    .pwr_on_o (pwr_on), .main_rst_no (mrst_n), .state_o (state), .timeout_err_o (err)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Supply model: power-good follows the power control after pg_delay cycles.
  int pcnt = 0;
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin pg = 1'b1; pcnt = 0; end
    else if (pg_stuck || pwr_on == pg) pcnt = 0;
    else begin
      pcnt++;
      if (pcnt >= pg_delay) begin pg = pwr_on; pcnt = 0; end
    end
  end

  // Edge monitor: cycle distances and conditions at every output edge.
  int cyc = 0, t_early = 0, t_pwr = 0, t_rst = 0, t_isof = 0;
  logic p_early = 0, p_iso = 0, p_pwr = 1, p_rst = 1, p_err = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (early && !p_early) begin
        t_early = cyc;
        check(err == 1'b0, "R8", "flag cleared on sleep accept", int'(err), 0);
      end
      if (iso && !p_iso)
        check(cyc - t_early == LEAD, "R2", "early-to-iso lead", cyc - t_early, LEAD);
      if (!pwr_on && p_pwr) begin
        check(flash == 1'b1, "R3", "flash ready at power cut", int'(flash), 1);
        check(iso && early, "R4", "isolated at power cut", int'(iso && early), 1);
        check(state == 4'd4, "R10", "state at power off", int'(state), 4);
        t_pwr = cyc;
      end
      if (pwr_on && !p_pwr) begin
        check(wake_given, "R5", "wake seen before power return", int'(wake_given), 1);
        t_pwr = cyc;
      end
      if (mrst_n && !p_rst) begin
        check(pg == 1'b1, "R6", "power good at reset release", int'(pg), 1);
        check(state == 4'd6, "R10", "state at reset release", int'(state), 6);
        t_rst = cyc;
      end
      if (!iso && p_iso) begin
        check(cyc - t_rst == HOLD, "R6", "reset-to-iso release", cyc - t_rst, HOLD);
        t_isof = cyc;
      end
      if (!early && p_early) begin
        check(cyc - t_isof == LAG, "R7", "iso-to-early release", cyc - t_isof, LAG);
        check(state == 4'd8, "R10", "state at early release", int'(state), 8);
      end
      if (err && !p_err)
        check(cyc - t_pwr == TO, "R8", "timeout distance", cyc - t_pwr, TO);
    end
    p_early = early; p_iso = iso; p_pwr = pwr_on; p_rst = mrst_n; p_err = err;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_sleep();
    step(); sleep = 1'b1; step(); sleep = 1'b0;
  endtask

  task automatic pulse_wake();
    step(); wake = 1'b1; wake_given = 1'b1; step(); wake = 1'b0;
  endtask

  task automatic wait_active();
    while (!(state == 4'd0 && !early)) step();
  endtask

  task automatic run_random(int wd, int fd, int d);
    bit back;
    wake_given = 1'b0;
    pg_delay = d;
    pulse_sleep();
    back = 1'b0;
    for (int k = 0; k < 600; k++) begin
      step();
      wake  = (k == wd);
      if (k == wd) wake_given = 1'b1;
      flash = (k >= fd);
      if (k > wd + 1 && state == 4'd0 && !early) begin back = 1'b1; break; end
    end
    wake = 1'b0; flash = 1'b0;
    check(back, "R5", "sequence returned to active", int'(back), 1);
  endtask

  initial begin
    void'($urandom(32'h51EE9));
    repeat (3) @(negedge clk);
    #1;
    check(!early && !iso && pwr_on && mrst_n, "R1", "controls in reset",
          int'({early, iso, pwr_on, mrst_n}), 4'b0011);
    check(state == 4'd0 && !err, "R1", "state and flag in reset", int'(state), 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 10; i++)
      run_random($urandom_range(0, 15), $urandom_range(0, 12), $urandom_range(1, 15));

    // R9: wake in active state does nothing
    pulse_wake();
    repeat (5) step();
    check(state == 4'd0 && pwr_on && !early, "R9", "wake ignored in active", int'(state), 0);
    wake_given = 1'b0;

    // R8: power-good stuck high after power cut
    pg_stuck = 1'b1;
    pulse_sleep();
    flash = 1'b1;
    while (pwr_on) step();
    repeat (TO + 3) step();
    check(err == 1'b1, "R8", "flag after stuck-high supply", int'(err), 1);
    pg_stuck = 1'b0;
    flash = 1'b0;
    pulse_wake();
    wait_active();

    // Normal run; the monitor confirms the flag clears on the next sleep.
    run_random(8, 2, 2);

    // R8 and R9: power-good stuck low after power return, sleep poked meanwhile
    wake_given = 1'b0;
    pg_delay = 2;
    pulse_sleep();
    flash = 1'b1;
    while (pwr_on || pg) step();
    pg_stuck = 1'b1;
    flash = 1'b0;
    pulse_wake();
    while (!pwr_on) step();
    pulse_sleep();
    repeat (TO + 3) step();
    check(err == 1'b1, "R8", "flag after stuck-low supply", int'(err), 1);
    check(state == 4'd5, "R9", "sleep ignored while waiting for power", int'(state), 5);
    pg_stuck = 1'b0;
    wait_active();
    repeat (5) step();
    check(state == 4'd0 && !early && pwr_on, "R9", "no new descent after ignored sleep",
          int'(state), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule